// File: doc/BRIEF.md
# Four-Operation ALU with Condition Flags

A purely combinational arithmetic-logic unit for a datapath. It takes two operands of a parameterised width (32 bits by default) and a 2-bit operation select. It returns a result word and a 4-bit condition nibble. The unit can add, subtract, AND and OR.

Addition and subtraction share one adder. For subtraction the second operand is inverted and the carry-in is forced to one, so the adder computes A + ~B + 1. The carry flag is the adder carry-out in both cases. After a subtraction it therefore reads 1 when no borrow occurred.

The negative and zero flags describe the result of every operation. The carry and overflow flags only carry meaning for the arithmetic operations and are held at zero for the logic operations.

Top module: `alu_core`

## Requirements
- R1: With operation select 2'b00 the result is (A + B) modulo 2^WIDTH.
- R2: With operation select 2'b01 the result is (A - B) modulo 2^WIDTH.
- R3: With operation select 2'b10 the result is the bitwise AND of A and B.
- R4: With operation select 2'b11 the result is the bitwise OR of A and B.
- R5: Flag bit 3 (negative) equals the most significant bit of the result for every operation.
- R6: Flag bit 2 (zero) is 1 exactly when every result bit is 0, for every operation.
- R7: Flag bit 1 (carry) is the carry-out of the unsigned addition for select 2'b00. For select 2'b01 it is 1 when A >= B unsigned, i.e. no borrow.
- R8: Flag bit 0 (overflow) is 1 when the signed two's-complement result of the add or subtract does not fit in WIDTH bits.
- R9: For select 2'b10 and 2'b11, flag bits 1 and 0 are both 0 whatever the operands are.
- R10: Add and subtract are served by a single adder; subtraction inverts B and sets the carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 2 | Operation select: 00 add, 01 subtract, 10 AND, 11 OR |
| result_o | output | WIDTH | Operation result |
| flags_o | output | 4 | Condition nibble {negative, zero, carry, overflow} |

## Verification
The bench builds the unit with WIDTH left at 32. At that width the signed boundaries 7FFFFFFF and 80000000, the all-ones word and the carry-out of bit 31 are all reached by hand-picked vectors. A directed table with hand-computed results and flags covers each operation. A pseudo-random sweep is then compared against a model that derives carry from an unsigned comparison and overflow from 64-bit signed arithmetic, not from an adder. Logic-operation vectors whose operands would carry if added show that carry and overflow stay clear.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FLG_N  = 3;
  localparam int unsigned FLG_Z  = 2;
  localparam int unsigned FLG_C  = 1;
  localparam int unsigned FLG_V  = 0;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  // R10: one adder; subtract = A + ~B + 1
  assign b_eff = sub_i ? ~b_i : b_i;
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i}) && sub_i) begin
      // R7
      sub_carry_chk: assert (cout_o == (a_i >= b_i));
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             or_sel_i,
  output logic [WIDTH-1:0] res_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign res_o[i] = or_sel_i ? (a_i[i] | b_i[i]) : (a_i[i] & b_i[i]);
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, or_sel_i}) && !or_sel_i) begin
      // R3
      and_subset_chk: assert (((res_o & ~a_i) == '0) && ((res_o & ~b_i) == '0));
    end
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_core_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]  res_i,
  input  logic              cout_i,
  input  logic              ovf_i,
  input  logic              arith_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_comb begin
    flags_o        = '0;
    flags_o[FLG_N] = res_i[WIDTH-1];
    flags_o[FLG_Z] = ~|res_i;
    flags_o[FLG_C] = arith_i & cout_i;
    flags_o[FLG_V] = arith_i & ovf_i;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_core_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [1:0]        op_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned MSB = WIDTH - 1;

  alu_op_e          op;
  logic             arith;
  logic [WIDTH-1:0] sum, lres;
  logic             cout, ovf;

  assign op    = alu_op_e'(op_i);
  assign arith = (op == OP_ADD) || (op == OP_SUB);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(op == OP_SUB),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .or_sel_i(op == OP_OR), .res_o(lres)
  );

  assign result_o = arith ? sum : lres;

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i(result_o), .cout_i(cout), .ovf_i(ovf), .arith_i(arith), .flags_o(flags_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      // R9
      logic_cv_chk: assert (arith || (flags_o[FLG_C] == 1'b0 && flags_o[FLG_V] == 1'b0));
      // R1
      add_ident_chk: assert (!(op == OP_ADD && b_i == '0) || result_o == a_i);
      // R6
      or_zero_chk: assert (!(op == OP_OR && (a_i | b_i) != '0) || !flags_o[FLG_Z]);
      // R5
      or_neg_chk: assert (!(op == OP_OR && a_i[MSB]) || flags_o[FLG_N]);
    end
  end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, res;
  logic [1:0]   op;
  logic [3:0]   flg;
  int           errors = 0, checks = 0, cycles = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  alu_core #(.WIDTH(W)) u0 (.a_i(a), .b_i(b), .op_i(op), .result_o(res), .flags_o(flg));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: expired at cycle %0d, expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] o, logic [W-1:0] x, logic [W-1:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
  endtask

  task automatic check_vec(logic [1:0] o, logic [W-1:0] x, logic [W-1:0] y,
                           logic [W-1:0] er, logic [3:0] ef);
    string rt;
    apply(o, x, y);
    rt = (o == 2'b00) ? "R1" : (o == 2'b01) ? "R2" : (o == 2'b10) ? "R3" : "R4";
    chk(rt, res, er);
    chk("R5", W'(flg[3]), W'(ef[3]));
    chk("R6", W'(flg[2]), W'(ef[2]));
    chk(o[1] ? "R9" : "R7", W'(flg[1]), W'(ef[1]));
    chk(o[1] ? "R9" : "R8", W'(flg[0]), W'(ef[0]));
  endtask

  task automatic test_idle;
    apply(2'b00, '0, '0);
    chk("R6", W'(flg), W'(4'b0100));
    chk("R1", res, '0);
  endtask

  task automatic test_add;
    check_vec(2'b00, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b1000);
    check_vec(2'b00, 32'h1, 32'hFFFFFFFF, 32'h0, 4'b0110);
    check_vec(2'b00, 32'hFF, 32'h1, 32'h100, 4'b0000);
    check_vec(2'b00, 32'h7FFFFFFF, 32'h1, 32'h80000000, 4'b1001);
    check_vec(2'b00, 32'h80000000, 32'h80000000, 32'h0, 4'b0111);
  endtask

  task automatic test_sub;
    check_vec(2'b01, 32'h0, 32'h0, 32'h0, 4'b0110);
    check_vec(2'b01, 32'h0, 32'hFFFFFFFF, 32'h1, 4'b0000);
    check_vec(2'b01, 32'h1, 32'h1, 32'h0, 4'b0110);
    check_vec(2'b01, 32'h100, 32'h1, 32'hFF, 4'b0010);
    check_vec(2'b01, 32'h80000000, 32'h1, 32'h7FFFFFFF, 4'b0011);
    check_vec(2'b01, 32'h0, 32'h1, 32'hFFFFFFFF, 4'b1000);
  endtask

  task automatic test_logic;
    check_vec(2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b1000);
    check_vec(2'b10, 32'hFFFFFFFF, 32'h12345678, 32'h12345678, 4'b0000);
    check_vec(2'b10, 32'h12345678, 32'h87654321, 32'h02244220, 4'b0000);
    check_vec(2'b10, 32'h0, 32'hFFFFFFFF, 32'h0, 4'b0100);
    check_vec(2'b11, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b1000);
    check_vec(2'b11, 32'h12345678, 32'h87654321, 32'h97755779, 4'b1000);
    check_vec(2'b11, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b1000);
    check_vec(2'b11, 32'h0, 32'h0, 32'h0, 4'b0100);
    check_vec(2'b11, 32'h80000000, 32'h80000000, 32'h80000000, 4'b1000);
  endtask

  task automatic test_sweep;
    logic [W-1:0] x = 32'h1D872B41, y = 32'h5A3C96E7;
    for (int i = 0; i < 400; i++) begin
      logic [1:0]    o = 2'(i);
      logic [W-1:0]  er;
      logic          ec, ev;
      longint signed sr;
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]} ^ 32'(i * 7);
      y = {y[0], y[31:1]} + 32'(i * 13);
      if (i % 50 == 0) y = x;
      ec = 1'b0; ev = 1'b0;
      case (o)
        2'b00: begin
          er = x + y; ec = (33'(x) + 33'(y)) > 33'hFFFFFFFF;
          sr = longint'($signed(x)) + longint'($signed(y));
          ev = (sr > 64'sh7FFFFFFF) || (sr < -64'sh80000000);
        end
        2'b01: begin
          er = x - y; ec = (x >= y);
          sr = longint'($signed(x)) - longint'($signed(y));
          ev = (sr > 64'sh7FFFFFFF) || (sr < -64'sh80000000);
        end
        2'b10: er = x & y;
        default: er = x | y;
      endcase
      check_vec(o, x, y, er, {er[W-1], er == '0, ec, ev});
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0;
    test_idle();
    test_add();
    test_sub();
    test_logic();
    test_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule